// File: doc/BRIEF.md
# Scripted Shared-Bus Master Requester

This block stands in for a bus master on a shared multiprocessor bus. It replays a short script of transactions held in an internal table. Each script entry gives three things: how long the agent keeps the bus once it has it, how many cycles separate the start of that ownership from the agent's next request, and the address to present while it owns the bus. A negative gap value marks the final entry.

The table is loaded through a simple write port while the agent is idle. A start pulse then arms the agent, together with a delay that places the first request. For each entry, the agent raises its request to an external round-robin arbiter and waits for the grant. It then pulls the shared busy line low for the programmed hold. The address-strobe line is pulled low in the first cycle of that period, and the address bus is driven throughout it.

The busy, strobe and activity lines are open-drain and the address bus is tri-state. Each one is therefore presented as separate value and drive-enable outputs, and the pull-ups and tri-state buffers sit outside the block. The activity line is held low from reset until the agent has released busy on its final transaction. A monitor elsewhere can then see when every agent has finished.

Top module: `bus_master_agent`

## Requirements
- R1: During and directly after reset, req is 0, busy_drive, strobe_drive and addr_en are 0, addr_out is 0, and active_drive is 1, which pulls the activity line low.
- R2: A start delay D raises req in cycle max(D,1) counted after the clock edge that samples start. D = 1 raises it in the first cycle after start, and D = 0 behaves as 1.
- R3: When grant is sampled high while req is high, busy_drive rises and req falls in the next cycle.
- R4: strobe_drive is 1 for exactly the first cycle of each busy period and 0 at every other time.
- R5: busy_drive stays 1 for max(H,1) cycles, where H is the entry's 8-bit hold count. addr_en is 1 exactly while busy_drive is 1, with addr_out equal to the entry's address. addr_out is 0 otherwise.
- R6: For a non-final entry with gap G, the next req rises max(G,H') cycles after busy_drive rose, where H' = max(H,1). A gap no longer than the hold raises req in the same cycle that busy falls, and req and busy_drive are never both 1.
- R7: A gap whose sign bit is set (0xFF = -1) marks the final entry. active_drive drops to 0 in the same cycle that busy_drive falls, and no req follows.
- R8: Entries are replayed in index order starting at index 0 on every start.
- R9: Table writes are ignored while a script is running, whether in the delay, request, hold or gap phases.
- R10: A start pulse accepted after a finished script re-arms the agent and pulls the activity line low again (active_drive = 1).
- R11: req stays high while grant is low, until a grant is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| tbl_we | input | 1 | Script table write enable (honoured only while idle) |
| tbl_idx | input | $clog2(DEPTH) | Script entry index to write |
| tbl_hold | input | CNT_W | Hold count in cycles (0 treated as 1) |
| tbl_gap | input | CNT_W | Signed gap from busy assertion to next request; negative ends the script |
| tbl_addr | input | ADDR_W | Address driven while holding the bus |
| start | input | 1 | Start pulse, accepted while idle or finished |
| start_delay | input | CNT_W | Cycle of the first request after start |
| grant | input | 1 | Grant from the arbiter |
| req | output | 1 | Bus request to the arbiter |
| busy_drive | output | 1 | 1 pulls the shared busy line low |
| strobe_drive | output | 1 | 1 pulls the shared address-strobe line low |
| active_drive | output | 1 | 1 pulls the shared activity line low |
| addr_out | output | ADDR_W | Address value for the tri-state bus |
| addr_en | output | 1 | Tri-state enable for addr_out |

## Verification
The scripts mix three gap cases: a gap longer than the hold, a gap shorter than the hold, and a gap equal to a hold of zero. Together they tell apart a request timed from busy assertion and one timed from busy release, and they show whether a zero hold is stretched to one cycle. Grant latencies of zero, one and two cycles confirm that the request is held and that busy follows the sampled grant, not the request. Start delays of 0, 1 and 3 separate an off-by-one in the first-request placement. A write issued in mid-script, followed by a restart from the finished state, shows that writes are blocked while running and that replay begins again at index 0 with the activity line pulled back low.

// File: rtl/bma_pkg.sv
package bma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DELAY,
    ST_REQ,
    ST_HOLD,
    ST_GAP,
    ST_DONE
  } agent_state_t;
endpackage

// File: rtl/script_table.sv
module script_table #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 48
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] widx,
  input  logic [WIDTH-1:0]         wdata,
  input  logic [$clog2(DEPTH)-1:0] ridx,
  output logic [WIDTH-1:0]         rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
    rdata <= mem[ridx];
  end
endmodule

// File: rtl/agent_sequencer.sv
module agent_sequencer
  import bma_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CNT_W-1:0]  start_delay,
  input  logic              grant,
  input  logic [CNT_W-1:0]  ent_hold,
  input  logic [CNT_W-1:0]  ent_gap,
  input  logic [ADDR_W-1:0] ent_addr,
  output logic [IDX_W-1:0]  ptr_nxt,
  output logic              idle,
  output logic              req,
  output logic              busy_drive,
  output logic              strobe_drive,
  output logic              active_drive,
  output logic [ADDR_W-1:0] addr_out,
  output logic              addr_en
);
  agent_state_t     state;
  logic [IDX_W-1:0] ptr;
  logic [CNT_W-1:0] dly_cnt, hold_rem, gap_rem;
  logic [CNT_W-1:0] hold_eff, gap_first;
  logic             is_final, release_now;

  always_comb begin
    is_final    = ent_gap[CNT_W-1];
    hold_eff    = (ent_hold == '0) ? CNT_W'(1) : ent_hold;
    gap_first   = (is_final || ent_gap == '0) ? '0 : ent_gap - CNT_W'(1);
    idle        = (state == ST_IDLE) || (state == ST_DONE);
    release_now = (state == ST_HOLD) && (hold_rem == '0);
    ptr_nxt     = ptr;
    if (idle && start)
      ptr_nxt = '0;
    else if (release_now && !is_final)
      ptr_nxt = (ptr == IDX_W'(DEPTH - 1)) ? '0 : ptr + IDX_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      ptr          <= '0;
      dly_cnt      <= '0;
      hold_rem     <= '0;
      gap_rem      <= '0;
      req          <= 1'b0;
      busy_drive   <= 1'b0;
      strobe_drive <= 1'b0;
      active_drive <= 1'b1;
      addr_out     <= '0;
      addr_en      <= 1'b0;
    end else begin
      ptr <= ptr_nxt;
      case (state)
        ST_IDLE, ST_DONE: begin
          if (start) begin
            active_drive <= 1'b1;
            if (start_delay <= CNT_W'(1)) begin
              state <= ST_REQ;
              req   <= 1'b1;
            end else begin
              state   <= ST_DELAY;
              dly_cnt <= start_delay - CNT_W'(2);
            end
          end
        end
        ST_DELAY: begin
          if (dly_cnt == '0) begin
            state <= ST_REQ;
            req   <= 1'b1;
          end else begin
            dly_cnt <= dly_cnt - CNT_W'(1);
          end
        end
        ST_REQ: begin
          if (grant) begin
            state        <= ST_HOLD;
            req          <= 1'b0;
            busy_drive   <= 1'b1;
            strobe_drive <= 1'b1;
            addr_en      <= 1'b1;
            addr_out     <= ent_addr;
            hold_rem     <= hold_eff - CNT_W'(1);
            gap_rem      <= gap_first;
          end
        end
        ST_HOLD: begin
          strobe_drive <= 1'b0;
          if (hold_rem == '0) begin
            busy_drive <= 1'b0;
            addr_en    <= 1'b0;
            addr_out   <= '0;
            if (is_final) begin
              state        <= ST_DONE;
              active_drive <= 1'b0;
            end else if (gap_rem == '0) begin
              state <= ST_REQ;
              req   <= 1'b1;
            end else begin
              state   <= ST_GAP;
              gap_rem <= gap_rem - CNT_W'(1);
            end
          end else begin
            hold_rem <= hold_rem - CNT_W'(1);
            if (gap_rem != '0) gap_rem <= gap_rem - CNT_W'(1);
          end
        end
        ST_GAP: begin
          if (gap_rem == '0) begin
            state <= ST_REQ;
            req   <= 1'b1;
          end else begin
            gap_rem <= gap_rem - CNT_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bus_master_agent.sv
module bus_master_agent #(
  parameter int DEPTH  = 16,
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     tbl_we,
  input  logic [$clog2(DEPTH)-1:0] tbl_idx,
  input  logic [CNT_W-1:0]         tbl_hold,
  input  logic [CNT_W-1:0]         tbl_gap,
  input  logic [ADDR_W-1:0]        tbl_addr,
  input  logic                     start,
  input  logic [CNT_W-1:0]         start_delay,
  input  logic                     grant,
  output logic                     req,
  output logic                     busy_drive,
  output logic                     strobe_drive,
  output logic                     active_drive,
  output logic [ADDR_W-1:0]        addr_out,
  output logic                     addr_en
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int ENT_W = 2 * CNT_W + ADDR_W;

  logic [IDX_W-1:0] ptr_nxt;
  logic             idle;
  logic [ENT_W-1:0] ent;

  script_table #(.DEPTH(DEPTH), .WIDTH(ENT_W)) u_table (
    .clk   (clk),
    .we    (tbl_we && idle),
    .widx  (tbl_idx),
    .wdata ({tbl_hold, tbl_gap, tbl_addr}),
    .ridx  (ptr_nxt),
    .rdata (ent)
  );

  agent_sequencer #(.DEPTH(DEPTH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_seq (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .start_delay  (start_delay),
    .grant        (grant),
    .ent_hold     (ent[ENT_W-1 -: CNT_W]),
    .ent_gap      (ent[ADDR_W +: CNT_W]),
    .ent_addr     (ent[ADDR_W-1:0]),
    .ptr_nxt      (ptr_nxt),
    .idle         (idle),
    .req          (req),
    .busy_drive   (busy_drive),
    .strobe_drive (strobe_drive),
    .active_drive (active_drive),
    .addr_out     (addr_out),
    .addr_en      (addr_en)
  );
endmodule

// File: rtl/bus_master_agent_chk.sv
module bus_master_agent_chk (
  input logic clk,
  input logic rst,
  input logic grant,
  input logic req,
  input logic busy_drive,
  input logic strobe_drive,
  input logic active_drive,
  input logic addr_en
);
  assert_grant_to_busy_R3: assert property (@(posedge clk) disable iff (rst)
    (req && grant) |=> (busy_drive && !req));

  assert_strobe_on_rise_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_drive) |-> strobe_drive);

  assert_strobe_single_R4: assert property (@(posedge clk) disable iff (rst)
    strobe_drive |=> !strobe_drive);

  assert_strobe_in_busy_R4: assert property (@(posedge clk) disable iff (rst)
    strobe_drive |-> busy_drive);

  assert_addr_follows_busy_R5: assert property (@(posedge clk) disable iff (rst)
    addr_en == busy_drive);

  assert_req_busy_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
    !(req && busy_drive));

  assert_quiet_when_done_R7: assert property (@(posedge clk) disable iff (rst)
    !active_drive |-> (!req && !busy_drive));

  assert_req_held_R11: assert property (@(posedge clk) disable iff (rst)
    (req && !grant) |=> req);
endmodule

bind bus_master_agent bus_master_agent_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .grant        (grant),
  .req          (req),
  .busy_drive   (busy_drive),
  .strobe_drive (strobe_drive),
  .active_drive (active_drive),
  .addr_en      (addr_en)
);

// File: tb/bus_master_agent_test.sv
`timescale 1ns/1ps
module bus_master_agent_test;
  localparam int DEPTH = 16;
  localparam int CNT_W = 8;
  localparam int ADDR_W = 32;

  typedef struct {
    logic [ADDR_W-1:0] addr;
    int                hold;
    int                k;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tbl_we = 1'b0;
  logic [3:0] tbl_idx = '0;
  logic [CNT_W-1:0] tbl_hold = '0, tbl_gap = '0, start_delay = '0;
  logic [ADDR_W-1:0] tbl_addr = '0;
  logic start = 1'b0;
  logic grant = 1'b0;
  logic req, busy_drive, strobe_drive, active_drive, addr_en;
  logic [ADDR_W-1:0] addr_out;

  int n_cmp = 0, n_bad = 0;
  int lat = 0;
  bit finished = 0;
  exp_t exp_q[$];

  always #2 clk = ~clk;

  bus_master_agent #(.DEPTH(DEPTH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst(rst), .tbl_we(tbl_we), .tbl_idx(tbl_idx),
    .tbl_hold(tbl_hold), .tbl_gap(tbl_gap), .tbl_addr(tbl_addr),
    .start(start), .start_delay(start_delay), .grant(grant),
    .req(req), .busy_drive(busy_drive), .strobe_drive(strobe_drive),
    .active_drive(active_drive), .addr_out(addr_out), .addr_en(addr_en)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // grant model: answers a request after lat cycles, drops it once req falls
  int wcnt = 0;
  always @(negedge clk) begin
    if (rst || !req) begin
      grant = 1'b0;
      wcnt = 0;
    end else if (!grant) begin
      if (wcnt >= lat) grant = 1'b1;
      else wcnt++;
    end
  end

  // monitor: pops expected transactions and compares observed bus activity
  logic prev_busy = 0, prev_req = 0;
  int cyc = 0, start_cyc = 0, blen = 0;
  bit wait_gap = 0;
  exp_t cur;
  always @(negedge clk) begin
    if (!rst) begin
      cyc++;
      if (busy_drive && !prev_busy) begin
        if (exp_q.size() == 0) begin
          check(0, "R8 unexpected transaction", addr_out, 0);
          cur.addr = '0; cur.hold = 0; cur.k = -1;
        end else begin
          cur = exp_q.pop_front();
        end
        start_cyc = cyc;
        blen = 0;
        check(addr_en && addr_out == cur.addr, "R5/R8 address", addr_out, cur.addr);
        check(strobe_drive, "R4 strobe first cycle", strobe_drive, 1);
      end
      if (busy_drive) begin
        blen++;
        if (prev_busy) check(!strobe_drive, "R4 strobe after first", strobe_drive, 0);
      end else begin
        check(!addr_en && addr_out == '0, "R5 bus released", addr_out, 0);
      end
      if (!busy_drive && prev_busy) begin
        check(blen == cur.hold, "R5 hold length", blen, cur.hold);
        if (cur.k < 0) check(!active_drive, "R7 activity released", active_drive, 0);
        else wait_gap = 1;
      end
      if (req && !prev_req && wait_gap) begin
        check(cyc - start_cyc == cur.k, "R6 request spacing", cyc - start_cyc, cur.k);
        wait_gap = 0;
      end
      prev_busy = busy_drive;
      prev_req = req;
    end
  end

  task automatic wr_raw(input int idx, input int h, input int g, input logic [ADDR_W-1:0] a);
    @(negedge clk);
    tbl_we = 1; tbl_idx = 4'(idx); tbl_hold = CNT_W'(h); tbl_gap = CNT_W'(g); tbl_addr = a;
    @(negedge clk);
    tbl_we = 0;
  endtask

  // driver: loads an entry and pushes its expected transaction
  task automatic add_entry(input int idx, input int h, input int g, input logic [ADDR_W-1:0] a);
    exp_t e;
    wr_raw(idx, h, g, a);
    e.addr = a;
    e.hold = (h == 0) ? 1 : h;
    e.k = (g < 0) ? -1 : ((g > e.hold) ? g : e.hold);
    exp_q.push_back(e);
  endtask

  task automatic do_start(input int d);
    int t;
    t = (d <= 1) ? 0 : d - 1;
    @(negedge clk);
    start = 1; start_delay = CNT_W'(d);
    @(negedge clk);
    start = 0;
    check(active_drive, "R10 activity pulled low on start", active_drive, 1);
    repeat (t) begin
      check(!req, "R2 request too early", req, 0);
      @(negedge clk);
    end
    check(req, "R2 request on schedule", req, 1);
  endtask

  task automatic wait_done();
    int n;
    n = 0;
    while (active_drive && n < 2000) begin
      @(negedge clk);
      n++;
    end
    check(!active_drive, "R7 script finished", active_drive, 0);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    n_cmp++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!req && !busy_drive && !strobe_drive && !addr_en && active_drive && addr_out == '0,
          "R1 reset state", {req, busy_drive, strobe_drive, addr_en, active_drive}, 5'b00001);
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(!req && !busy_drive && active_drive, "R1 after reset", {req, busy_drive, active_drive}, 3'b001);

    // run A: gap > hold, gap < hold, zero hold, final
    lat = 0;
    add_entry(0, 3, 5, 32'h0000_1000);
    add_entry(1, 4, 2, 32'h0000_2000);
    add_entry(2, 0, 1, 32'h0000_3000);
    add_entry(3, 2, -1, 32'h0000_4000);
    do_start(3);
    wait_done();
    repeat (20) begin
      @(negedge clk);
      check(!req && !active_drive, "R7 no request after final", req, 0);
    end

    // run B: grant latency, write during run must be ignored (R9, R11)
    lat = 2;
    add_entry(0, 2, 3, 32'h0000_AAAA);
    add_entry(1, 1, -1, 32'h0000_BBBB);
    do_start(1);
    check(req && !busy_drive, "R11 waiting for grant", req, 1);
    @(negedge clk);
    check(req && !busy_drive, "R11 request held", req, 1);
    while (!busy_drive) @(negedge clk);
    wr_raw(1, 7, -1, 32'hDEAD_BEEF);
    wait_done();

    // run C: restart from finished state with D=0, gap shorter than hold
    lat = 1;
    add_entry(0, 5, 2, 32'h0000_0055);
    add_entry(1, 1, -1, 32'h0000_0066);
    do_start(0);
    wait_done();
    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "R8 all entries replayed", exp_q.size(), 0);
    report();
  end
endmodule